// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder

This block steers every memory access that lands in the legacy window 0xA0000 to 0xFFFFF. For each access it reports whether the access goes to system RAM or is passed on to the expansion bus. It also reports whether a write must be dropped because the segment is read-only. Addresses outside the window always go to RAM with writes allowed.

Software programs the routing through a byte-wide configuration port. One register controls the 64 KB top segment. Six registers each pack two 2-bit attributes, one for each of twelve 16 KB option-ROM segments. A graphics-window control register opens 0xA0000 to 0xBFFFF to RAM, either always or only while the processor runs in system-management mode (SMM).

The decode is purely combinational on the address, the write strobe and the SMM input. The memory arrays and the bus protocols sit outside this block.

Top module: `legwin_decoder`

## Requirements
- R1: After reset, the registers at offsets 0x59 to 0x5F read 0x00 and the graphics control register at 0x72 reads 0x02. As a result, every address in the window selects the expansion bus (`sel_ram`=0).
- R2: A write through the configuration port to offset 0x59, 0x5A to 0x5F or 0x72 stores the full byte. That byte reads back on `cfg_rdata` while `cfg_addr` holds the offset. Any other offset reads 0x00, and writes to it change neither read-back nor routing.
- R3: Addresses 0xF0000 to 0xFFFFF take their attribute from bits [5:4] of offset 0x59. Bits [3:0] and [7:6] of that register have no effect on routing.
- R4: ROM segment i (0 to 11) covers 0xC0000 + 0x4000·i up to the next boundary. It takes its attribute from offset 0x5A + (i>>1), bits [1:0] for even i and bits [5:4] for odd i.
- R5: Attribute encoding. Value 3 sends reads and writes to RAM. Value 1 sends the access to RAM and raises `wr_inhibit` for writes only. Values 0 and 2 select the expansion bus. `wr_inhibit` is never raised for a read.
- R6: Addresses 0xA0000 to 0xBFFFF select RAM when bit 6 of offset 0x72 is set, or when `smm_active` is high and bit 3 is set. Otherwise they select the expansion bus. `wr_inhibit` stays low in this range.
- R7: Addresses below 0xA0000 or above 0xFFFFF select RAM with `wr_inhibit` low.
- R8: Routing follows the address, the write strobe and `smm_active` in the same cycle. A configuration write takes effect from the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read-back of the register at `cfg_addr` |
| mem_addr | input | ADDR_W | Access address |
| mem_write | input | 1 | 1 = write access, 0 = read access |
| smm_active | input | 1 | Processor is in system-management mode |
| sel_ram | output | 1 | 1 = system RAM, 0 = expansion bus |
| wr_inhibit | output | 1 | Write must be discarded (read-only segment) |

## Verification
The checker assumes that `mem_addr`, `mem_write` and `smm_active` are settled before each sampling edge. It also assumes that `cfg_addr` is stable across a cycle when a read-back is compared. The bench meets both assumptions by changing every input only on the falling clock edge. It also never drives a configuration write in the same cycle as an access whose result it scores. This keeps the stored attributes constant whenever an expected route is compared.

// File: rtl/legwin_pkg.sv
// Package: shared constants and types for the legacy window decoder.
// Assumes the window lies in the low 1 MB and the config space is 8 bits wide.
package legwin_pkg;
    localparam logic [7:0]  CFG_HI_SEG    = 8'h59;
    localparam logic [7:0]  CFG_ROM_BASE  = 8'h5A;
    localparam logic [7:0]  CFG_GFX       = 8'h72;
    localparam logic [7:0]  GFX_RST       = 8'h02;
    localparam int          GFX_OPEN_BIT  = 6;
    localparam int          GFX_SMM_BIT   = 3;
    localparam logic [19:0] WIN_LO        = 20'hA0000;
    localparam logic [19:0] ROM_LO        = 20'hC0000;
    localparam logic [19:0] HI_LO         = 20'hF0000;
    localparam logic [19:0] WIN_HI        = 20'hFFFFF;
    localparam int          ROM_SEG_SHIFT = 14;

    typedef enum logic [1:0] {
        RGN_OUTSIDE = 2'd0,
        RGN_GFX     = 2'd1,
        RGN_ATTR    = 2'd2
    } region_e;
endpackage

// File: rtl/legwin_cfg_regs.sv
// Module: configuration register file (top-segment, packed ROM, graphics control).
// Assumes single-byte writes; unknown offsets read as zero and ignore writes.
module legwin_cfg_regs
    import legwin_pkg::*;
#(
    parameter int N_ROM_SEG = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [7:0]                cfg_addr,
    input  logic [7:0]                cfg_wdata,
    output logic [7:0]                cfg_rdata,
    output logic [1:0]                hi_attr,
    output logic [N_ROM_SEG-1:0][1:0] rom_attr,
    output logic [7:0]                gfx_ctl
);
    localparam int N_ROM_REGS = (N_ROM_SEG + 1) / 2;

    logic [7:0] hi_q;
    logic [7:0] gfx_q;
    logic [7:0] rom_q [N_ROM_REGS];

    // Top-segment register storage
    always_ff @(posedge clk) begin
        if (!rst_n)                                hi_q <= 8'h00;
        else if (cfg_we && cfg_addr == CFG_HI_SEG) hi_q <= cfg_wdata;
    end

    // Graphics control register storage
    always_ff @(posedge clk) begin
        if (!rst_n)                             gfx_q <= GFX_RST;
        else if (cfg_we && cfg_addr == CFG_GFX) gfx_q <= cfg_wdata;
    end

    generate
        for (genvar g = 0; g < N_ROM_REGS; g++) begin : g_rom_reg
            // Packed ROM-attribute register g storage
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rom_q[g] <= 8'h00;
                else if (cfg_we && cfg_addr == CFG_ROM_BASE + 8'(g))
                    rom_q[g] <= cfg_wdata;
            end
        end
        for (genvar s = 0; s < N_ROM_SEG; s++) begin : g_rom_attr
            assign rom_attr[s] = rom_q[s / 2][4 * (s % 2) +: 2];
        end
    endgenerate

    assign hi_attr = hi_q[5:4];
    assign gfx_ctl = gfx_q;

    // Read-back multiplexer
    always_comb begin
        cfg_rdata = 8'h00;
        if (cfg_addr == CFG_HI_SEG) cfg_rdata = hi_q;
        if (cfg_addr == CFG_GFX)    cfg_rdata = gfx_q;
        for (int i = 0; i < N_ROM_REGS; i++) begin
            if (cfg_addr == CFG_ROM_BASE + 8'(i)) cfg_rdata = rom_q[i];
        end
    end
endmodule

// File: rtl/legwin_seg_decode.sv
// Module: classifies an address into outside / graphics / attribute-controlled,
// and selects the 2-bit attribute for attribute-controlled addresses.
// Assumes ADDR_W >= 20.
module legwin_seg_decode
    import legwin_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int N_ROM_SEG = 12
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [1:0]                hi_attr,
    input  logic [N_ROM_SEG-1:0][1:0] rom_attr,
    output region_e                   region,
    output logic [1:0]                attr
);
    localparam int SEG_W = $clog2(N_ROM_SEG + 1);
    localparam logic [ADDR_W-1:0] A_WIN_LO = ADDR_W'(WIN_LO);
    localparam logic [ADDR_W-1:0] A_ROM_LO = ADDR_W'(ROM_LO);
    localparam logic [ADDR_W-1:0] A_HI_LO  = ADDR_W'(HI_LO);
    localparam logic [ADDR_W-1:0] A_WIN_HI = ADDR_W'(WIN_HI);

    logic [ADDR_W-1:0] rom_off;
    logic [SEG_W-1:0]  seg_idx;

    assign rom_off = addr - A_ROM_LO;
    assign seg_idx = rom_off[ROM_SEG_SHIFT +: SEG_W];

    // Region classification and attribute selection
    always_comb begin
        region = RGN_OUTSIDE;
        attr   = 2'b00;
        if (addr >= A_WIN_LO && addr <= A_WIN_HI) begin
            if (addr < A_ROM_LO) begin
                region = RGN_GFX;
            end else if (addr >= A_HI_LO) begin
                region = RGN_ATTR;
                attr   = hi_attr;
            end else begin
                region = RGN_ATTR;
                for (int s = 0; s < N_ROM_SEG; s++) begin
                    if (seg_idx == SEG_W'(s)) attr = rom_attr[s];
                end
            end
        end
    end
endmodule

// File: rtl/legwin_route.sv
// Module: turns region, attribute, graphics control and SMM into a target
// select and a write-inhibit flag. Purely combinational.
module legwin_route
    import legwin_pkg::*;
(
    input  region_e    region,
    input  logic [1:0] attr,
    input  logic [7:0] gfx_ctl,
    input  logic       smm_active,
    input  logic       mem_write,
    output logic       sel_ram,
    output logic       wr_inhibit
);
    logic gfx_open;

    assign gfx_open = gfx_ctl[GFX_OPEN_BIT] | (smm_active & gfx_ctl[GFX_SMM_BIT]);

    // Route selection per region
    always_comb begin
        sel_ram    = 1'b1;
        wr_inhibit = 1'b0;
        unique case (region)
            RGN_GFX:  sel_ram = gfx_open;
            RGN_ATTR: begin
                sel_ram    = attr[0];
                wr_inhibit = mem_write & (attr == 2'b01);
            end
            default:  sel_ram = 1'b1;
        endcase
    end
endmodule

// File: rtl/legwin_decoder.sv
// Module: top of the legacy memory attribute decoder. Holds the config
// registers and decodes each access combinationally.
// Assumes config writes and scored accesses do not share a cycle.
module legwin_decoder
    import legwin_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int N_ROM_SEG = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_write,
    input  logic              smm_active,
    output logic              sel_ram,
    output logic              wr_inhibit
);
    logic [1:0]                hi_attr;
    logic [N_ROM_SEG-1:0][1:0] rom_attr;
    logic [7:0]                smram_q;
    region_e                   region;
    logic [1:0]                attr;

    legwin_cfg_regs #(.N_ROM_SEG(N_ROM_SEG)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .hi_attr   (hi_attr),
        .rom_attr  (rom_attr),
        .gfx_ctl   (smram_q)
    );

    legwin_seg_decode #(.ADDR_W(ADDR_W), .N_ROM_SEG(N_ROM_SEG)) u_dec (
        .addr     (mem_addr),
        .hi_attr  (hi_attr),
        .rom_attr (rom_attr),
        .region   (region),
        .attr     (attr)
    );

    legwin_route u_route (
        .region     (region),
        .attr       (attr),
        .gfx_ctl    (smram_q),
        .smm_active (smm_active),
        .mem_write  (mem_write),
        .sel_ram    (sel_ram),
        .wr_inhibit (wr_inhibit)
    );
endmodule

// File: rtl/legwin_decoder_chk.sv
// Module: property checker bound to legwin_decoder.
// Assumes inputs are stable around the sampling edge.
module legwin_decoder_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [7:0]        cfg_addr,
    input logic [7:0]        cfg_rdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_write,
    input logic              smm_active,
    input logic              sel_ram,
    input logic              wr_inhibit,
    input logic [7:0]        smram_q
);
    localparam logic [ADDR_W-1:0] C_LO  = ADDR_W'(20'hA0000);
    localparam logic [ADDR_W-1:0] C_ROM = ADDR_W'(20'hC0000);
    localparam logic [ADDR_W-1:0] C_HI  = ADDR_W'(20'hFFFFF);

    logic outside;
    logic in_gfx;
    assign outside = (mem_addr < C_LO) || (mem_addr > C_HI);
    assign in_gfx  = (mem_addr >= C_LO) && (mem_addr < C_ROM);

    assert_outside_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
        outside |-> (sel_ram && !wr_inhibit));

    assert_read_not_inhibited_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_write |-> !wr_inhibit);

    assert_inhibit_on_ram_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_inhibit |-> sel_ram);

    assert_gfx_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_gfx |-> (!wr_inhibit &&
                    sel_ram == (smram_q[6] || (smm_active && smram_q[3]))));

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> (!$stable(cfg_addr) || $stable(cfg_rdata)));
endmodule

bind legwin_decoder legwin_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_rdata  (cfg_rdata),
    .mem_addr   (mem_addr),
    .mem_write  (mem_write),
    .smm_active (smm_active),
    .sel_ram    (sel_ram),
    .wr_inhibit (wr_inhibit),
    .smram_q    (smram_q)
);

// File: tb/legwin_decoder_bench.sv
module legwin_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;

    typedef struct {
        logic  ram;
        logic  inh;
        logic [31:0] addr;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [7:0]        cfg_addr = 8'h00;
    logic [7:0]        cfg_wdata = 8'h00;
    logic [7:0]        cfg_rdata;
    logic [ADDR_W-1:0] mem_addr = '0;
    logic              mem_write = 1'b0;
    logic              smm_active = 1'b0;
    logic              sel_ram;
    logic              wr_inhibit;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 0;
    exp_t sb_q[$];
    logic [7:0] shadow [256];

    always #(CLK_PERIOD / 2) clk = ~clk;

    legwin_decoder #(.ADDR_W(ADDR_W)) u_legwin_decoder (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
        .mem_addr, .mem_write, .smm_active, .sel_ram, .wr_inhibit
    );

    function automatic bit known_off(input logic [7:0] off);
        return off == 8'h59 || off == 8'h72 || (off >= 8'h5A && off <= 8'h5F);
    endfunction

    // Reference model built from the requirements
    function automatic exp_t model(input logic [31:0] a, input logic w, input logic s);
        exp_t e;
        logic [1:0] at;
        int seg;
        e.addr = a; e.inh = 1'b0; e.ram = 1'b1;
        if (a < 32'hA0000 || a > 32'hFFFFF) begin
            e.ram = 1'b1;
        end else if (a < 32'hC0000) begin
            e.ram = shadow[8'h72][6] | (s & shadow[8'h72][3]);
        end else begin
            if (a >= 32'hF0000) at = shadow[8'h59][5:4];
            else begin
                seg = int'((a - 32'hC0000) >> 14);
                at  = shadow[8'h5A + 8'(seg / 2)][4 * (seg % 2) +: 2];
            end
            e.ram = (at == 2'd3) || (at == 2'd1);
            e.inh = w && (at == 2'd1);
        end
        return e;
    endfunction

    task automatic access(input logic [31:0] a, input logic w, input logic s, input string tag);
        exp_t e;
        @(negedge clk);
        mem_addr = a; mem_write = w; smm_active = s;
        #1;
        e = model(a, w, s);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic cfg_write(input logic [7:0] off, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = off; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        if (known_off(off)) shadow[off] = val;
    endtask

    task automatic cfg_check(input logic [7:0] off, input string tag);
        logic [7:0] exp_v;
        @(negedge clk);
        cfg_addr = off;
        #1;
        exp_v = known_off(off) ? shadow[off] : 8'h00;
        n_checks++;
        if (cfg_rdata !== exp_v) begin
            n_fails++;
            $display("FAIL %s: offset %h rdata actual %h expected %h", tag, off, cfg_rdata, exp_v);
        end
    endtask

    // Scoreboard monitor: pops expectations and compares outputs mid-cycle
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #(CLK_PERIOD / 4);
            while (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                n_checks++;
                if (sel_ram !== e.ram || wr_inhibit !== e.inh) begin
                    n_fails++;
                    $display("FAIL %s: addr %h sel_ram/wr_inhibit actual %b%b expected %b%b",
                             e.tag, e.addr, sel_ram, wr_inhibit, e.ram, e.inh);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = 8'h00;
        shadow[8'h72] = 8'h02;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values and reset routing
        for (int i = 0; i < 7; i++) cfg_check(8'h59 + 8'(i), "R1 reset attr reg");
        cfg_check(8'h72, "R1 reset gfx ctl");
        access(32'hF0000, 1'b0, 1'b0, "R1 reset top seg");
        access(32'hC4000, 1'b1, 1'b0, "R1 reset rom seg");
        access(32'hA0000, 1'b0, 1'b1, "R1 reset gfx");

        // R7: outside the window
        access(32'h0009FFFF, 1'b1, 1'b0, "R7 below window");
        access(32'h00100000, 1'b1, 1'b0, "R7 above window");
        access(32'h00000000, 1'b0, 1'b1, "R7 zero address");

        // R3 / R5: top segment through every attribute value
        for (int v = 0; v < 4; v++) begin
            cfg_write(8'h59, 8'(v << 4));
            cfg_check(8'h59, "R2 top readback");
            access(32'hF0000, 1'b0, 1'b0, "R3 R5 top read");
            access(32'hFFFFF, 1'b1, 1'b0, "R3 R5 top write");
        end
        cfg_write(8'h59, 8'hCF);
        access(32'hF8000, 1'b1, 1'b0, "R3 other bits ignored");
        cfg_write(8'h59, 8'h10);
        access(32'hF0000, 1'b1, 1'b0, "R5 write inhibited");
        access(32'hF0000, 1'b0, 1'b0, "R5 read allowed");

        // R4: packed ROM segments with distinct attributes
        cfg_write(8'h5A, 8'h31);
        cfg_write(8'h5B, 8'h13);
        cfg_write(8'h5C, 8'h20);
        cfg_write(8'h5D, 8'h02);
        cfg_write(8'h5E, 8'hC3);
        cfg_write(8'h5F, 8'h1D);
        for (int i = 0; i < 6; i++) cfg_check(8'h5A + 8'(i), "R2 rom readback");
        for (int s = 0; s < 12; s++) begin
            access(32'hC0000 + 32'(s) * 32'h4000,          1'b1, 1'b0, "R4 seg first write");
            access(32'hC0000 + 32'(s) * 32'h4000 + 32'h3FFF, 1'b0, 1'b0, "R4 seg last read");
            access(32'hC0000 + 32'(s) * 32'h4000 + 32'h2000, 1'b1, 1'b1, "R4 seg mid write");
        end
        access(32'hEFFFF, 1'b1, 1'b0, "R4 boundary below top");

        // R2: unknown offsets ignored
        cfg_write(8'h58, 8'hFF);
        cfg_write(8'h60, 8'hFF);
        cfg_write(8'h71, 8'hFF);
        cfg_write(8'h73, 8'hFF);
        cfg_check(8'h58, "R2 unknown reads zero");
        cfg_check(8'h73, "R2 unknown reads zero");
        cfg_check(8'h59, "R2 neighbour intact");
        access(32'hA8000, 1'b0, 1'b1, "R2 gfx unchanged");
        access(32'hC0000, 1'b1, 1'b0, "R2 rom unchanged");

        // R6 / R8: graphics window, SMM toggles in consecutive cycles
        cfg_write(8'h72, 8'h08);
        cfg_check(8'h72, "R2 gfx readback");
        access(32'hA0000, 1'b1, 1'b0, "R6 smm off closed");
        access(32'hA0000, 1'b1, 1'b1, "R6 R8 smm on open");
        access(32'hBFFFF, 1'b0, 1'b0, "R6 R8 smm off again");
        cfg_write(8'h72, 8'h40);
        access(32'hBFFFF, 1'b1, 1'b0, "R6 forced open");
        access(32'hB0000, 1'b0, 1'b1, "R6 forced open smm");
        cfg_write(8'h72, 8'h02);
        access(32'hA0000, 1'b0, 1'b1, "R6 closed with smm");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule